// File: doc/BRIEF.md
# Multi-Segment Guest-to-Host Address Translator

This block turns a guest-physical address into a host-physical address. It does so by comparing the address against a small ordered set of contiguous memory segments, then adding an offset. No second-level page walk is made. Each segment pairs a guest start address with a host start address. A segment's guest size comes from the gap to the next guest start. The last used segment ends where its host range reaches one shared limit register.

Software fills the segment registers through a configuration write port, in ascending segment order, before any traffic is sent. Requests arrive on a valid/ready port. The answer appears one cycle after a request is accepted. It carries either the host address, a violation flag when no segment holds the guest address, or a bypass flag when segment translation is switched off.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rspValid` is 0 and `reqReady` is 1. All segment registers, the limit and the mode bit reset to zero.
- R2: Segment 0 starts at guest address 0 and ends one below guest base 1. An address in it maps to host base 0 plus the address.
- R3: An address in an intermediate segment j (from guest base j up to one below guest base j+1) maps to host base j + (address − guest base j). When several segments could match, the lowest index wins.
- R4: The last used segment j covers guest addresses up to guest base j + (limit − host base j), with that end included. An address above it is a violation. A violation gives `rspViol`=1 and `rspHpa`=0.
- R5: The number of used segments k is the index of the first guest base register, at index 1 or above, that holds zero. It is N when no such register exists. Host base registers at index k and above have no effect.
- R6: With a single used segment, the result is host base 0 plus the address. A violation is flagged exactly when that sum exceeds the limit.
- R7: While the mode register is zero, a request returns `rspBypass`=1, `rspViol`=0 and `rspHpa` equal to the request address. A write of any nonzero value enables segment translation.
- R8: The response is valid in the cycle after the request is accepted. While `rspValid`=1 and `rspReady`=0, the response holds stable and `reqReady` is 0.
- R9: A configuration write made while `rspValid`=1 is ignored.
- R10: Configuration writes use `cfgKind` 0 for a host base, 1 for a guest base, 2 for the limit and 3 for the mode, with `cfgIdx` selecting the segment. A guest base write to index 0 is ignored, and so is any index of N or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | Register kind: 0 host base, 1 guest base, 2 limit, 3 mode |
| cfgIdx | input | IDX_W | Segment index of the write |
| cfgData | input | ADDR_W | Write data |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqGpa | input | ADDR_W | Guest-physical address |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response consumed |
| rspHpa | output | ADDR_W | Host-physical address (zero on violation, the guest address in bypass) |
| rspViol | output | 1 | No segment contains the address |
| rspBypass | output | 1 | Translation disabled; request passed through |

## Verification
Directed layouts with one segment and with three of four segments probe each segment's first and last address and the first address past the last segment. These cases tell a wrong bound from a wrong offset. Random layouts with 1 to N segments, random sizes and scattered host bases are compared against a model built from segment start and size. That model never uses the register formula, so errors in the derived segment count or in the limit-based end show up separately. Extra cases cover junk host bases past the used count, a write to guest base 0, bypass mode, and a held response under backpressure with a configuration write attempted during the hold.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    KIND_HOST  = 2'd0,
    KIND_GUEST = 2'd1,
    KIND_LIMIT = 2'd2,
    KIND_MODE  = 2'd3
  } cfgKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // request accepted this cycle
    logic cfgWe;    // configuration write allowed this cycle
    logic hold;     // response pending and stalled
  } xlStrobe_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rspReady,
  input  logic      cfgWrEn,
  output logic      reqReady,
  output logic      rspValid,
  output xlStrobe_t strobe
);

  logic rspValidQ;

  assign rspValid = rspValidQ;
  assign reqReady = !rspValidQ || rspReady;

  always_comb begin
    strobe.capture = reqValid && reqReady;
    strobe.cfgWe   = cfgWrEn && !rspValidQ;
    strobe.hold    = rspValidQ && !rspReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
    end else if (strobe.capture) begin
      rspValidQ <= 1'b1;
    end else if (rspReady) begin
      rspValidQ <= 1'b0;
    end
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R8
  one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_N  = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (SEG_N > 1) ? $clog2(SEG_N) : 1,
  localparam int CNT_W = $clog2(SEG_N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobe_t         strobe,
  input  logic [1:0]        cfgKind,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqGpa,
  output logic [ADDR_W-1:0] rspHpa,
  output logic              rspViol,
  output logic              rspBypass
);

  logic [ADDR_W-1:0] hostBase  [SEG_N];
  logic [ADDR_W-1:0] guestBase [SEG_N];  // index 0 stays zero
  logic [ADDR_W-1:0] limitReg;
  logic              modeReg;

  logic [CNT_W-1:0]  segCount;
  logic [SEG_N-1:0]  segHit;
  logic [ADDR_W-1:0] segHpa [SEG_N];
  logic              anyHit;
  logic [ADDR_W-1:0] selHpa;
  logic              idxOk;

  assign idxOk = (32'(cfgIdx) < SEG_N);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_N; i++) begin
        hostBase[i]  <= '0;
        guestBase[i] <= '0;
      end
      limitReg <= '0;
      modeReg  <= 1'b0;
    end else if (strobe.cfgWe) begin
      case (cfgKind_e'(cfgKind))
        KIND_HOST:  if (idxOk) hostBase[cfgIdx] <= cfgData;
        KIND_GUEST: if (idxOk && cfgIdx != '0) guestBase[cfgIdx] <= cfgData;
        KIND_LIMIT: limitReg <= cfgData;
        KIND_MODE:  modeReg  <= (cfgData != '0);
        default: ;
      endcase
    end
  end

  // used segment count: first zero guest base at index 1 or above
  always_comb begin
    segCount = CNT_W'(SEG_N);
    for (int i = SEG_N - 1; i >= 1; i--) begin
      if (guestBase[i] == '0) segCount = CNT_W'(i);
    end
  end

  // per-segment compare and add
  for (genvar j = 0; j < SEG_N; j++) begin : g_seg
    logic              used;
    logic              isLast;
    logic              geLo;
    logic [ADDR_W-1:0] offs;
    logic              lastIn;
    assign used   = (32'(segCount) > j);
    assign isLast = (32'(segCount) == j + 1);
    assign geLo   = (reqGpa >= guestBase[j]);
    assign offs   = reqGpa - guestBase[j];
    assign lastIn = (limitReg >= hostBase[j]) && (offs <= (limitReg - hostBase[j]));
    if (j < SEG_N - 1) begin : g_mid
      assign segHit[j] = used && geLo &&
                         (isLast ? lastIn : (reqGpa < guestBase[j+1]));
    end else begin : g_end
      assign segHit[j] = used && geLo && lastIn;
    end
    assign segHpa[j] = hostBase[j] + offs;
  end

  // lowest matching index wins
  always_comb begin
    anyHit = 1'b0;
    selHpa = '0;
    for (int j = SEG_N - 1; j >= 0; j--) begin
      if (segHit[j]) begin
        anyHit = 1'b1;
        selHpa = segHpa[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHpa    <= '0;
      rspViol   <= 1'b0;
      rspBypass <= 1'b0;
    end else if (strobe.capture) begin
      if (!modeReg) begin
        rspHpa    <= reqGpa;
        rspViol   <= 1'b0;
        rspBypass <= 1'b1;
      end else begin
        rspHpa    <= anyHit ? selHpa : '0;
        rspViol   <= !anyHit;
        rspBypass <= 1'b0;
      end
    end
  end

  // R8
  rsp_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> ($stable(rspHpa) && $stable(rspViol) && $stable(rspBypass)));

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> ($stable(limitReg) && $stable(modeReg)));

  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !modeReg) |=> (rspBypass && !rspViol && rspHpa == $past(reqGpa)));

  // R4
  viol_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspViol |-> (rspHpa == '0 && !rspBypass));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_N  = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (SEG_N > 1) ? $clog2(SEG_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgKind,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqGpa,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspHpa,
  output logic              rspViol,
  output logic              rspBypass
);

  xlStrobe_t strobe;

  seg_xlate_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .cfgWrEn  (cfgWrEn),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  seg_xlate_dp #(.SEG_N(SEG_N), .ADDR_W(ADDR_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgKind   (cfgKind),
    .cfgIdx    (cfgIdx),
    .cfgData   (cfgData),
    .reqGpa    (reqGpa),
    .rspHpa    (rspHpa),
    .rspViol   (rspViol),
    .rspBypass (rspBypass)
  );

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgKind = '0;
  logic [IW-1:0] cfgIdx = '0;
  logic [AW-1:0] cfgData = '0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [AW-1:0] reqGpa = '0;
  logic rspValid;
  logic rspReady = 1'b1;
  logic [AW-1:0] rspHpa;
  logic rspViol;
  logic rspBypass;

  int chkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  // bench segment model: guest start, size, host start
  logic [AW-1:0] sGb [N];
  logic [AW-1:0] sSz [N];
  logic [AW-1:0] sHb [N];
  int kUsed = 1;
  bit modeOn = 1'b0;

  always #2 clk = ~clk;

  seg_xlate #(.SEG_N(N), .ADDR_W(AW)) i_seg_xlate (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgKind(cfgKind), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .reqValid(reqValid), .reqReady(reqReady), .reqGpa(reqGpa),
    .rspValid(rspValid), .rspReady(rspReady), .rspHpa(rspHpa), .rspViol(rspViol),
    .rspBypass(rspBypass)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {bypass, viol, hpa} from the segment list
  function automatic logic [AW+1:0] model(logic [AW-1:0] g);
    if (!modeOn) return {1'b1, 1'b0, g};
    for (int j = 0; j < kUsed; j++) begin
      if (g >= sGb[j] && (g - sGb[j]) < sSz[j])
        return {1'b0, 1'b0, sHb[j] + (g - sGb[j])};
    end
    return {1'b0, 1'b1, {AW{1'b0}}};
  endfunction

  task automatic wrCfg(int kind, int idx, logic [AW-1:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgKind = 2'(kind); cfgIdx = IW'(idx); cfgData = d;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // load the bench segment list in ascending order, zeroes for unused
  task automatic loadSegs(bit junkHost);
    for (int j = 0; j < N; j++) begin
      if (j < kUsed) wrCfg(0, j, sHb[j]);
      else wrCfg(0, j, junkHost ? $urandom : 32'd0);
      if (j >= 1) wrCfg(1, j, (j < kUsed) ? sGb[j] : 32'd0);
    end
    wrCfg(2, 0, sHb[kUsed-1] + sSz[kUsed-1] - 1);
  endtask

  task automatic doReq(string req, logic [AW-1:0] g);
    logic [AW+1:0] e;
    e = model(g);
    @(negedge clk);
    reqValid = 1'b1; reqGpa = g;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " rspValid"}, 64'(rspValid), 64'd1);
    check(req, {30'd0, rspBypass, rspViol, rspHpa}, {30'd0, e});
  endtask

  initial begin
    int cycles = 0;
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      failCnt++;
      chkCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 rspValid", 64'(rspValid), 64'd0);
    check("R1 reqReady", 64'(reqReady), 64'd1);
    modeOn = 1'b0;
    doReq("R1 R7 bypass after reset", 32'h0000_abcd);

    // R6 single segment
    kUsed = 1; sGb[0] = 0; sSz[0] = 32'h1000; sHb[0] = 32'h1000;
    loadSegs(1'b0);
    wrCfg(3, 0, 32'd1); modeOn = 1'b1;
    doReq("R6 first", 32'h0);
    doReq("R6 last", 32'hfff);
    doReq("R6 beyond limit", 32'h1000);
    doReq("R6 far", 32'h8000_0000);

    // three of four segments
    kUsed = 3;
    sGb[0] = 0;        sSz[0] = 32'h100; sHb[0] = 32'h10000;
    sGb[1] = 32'h100;  sSz[1] = 32'h200; sHb[1] = 32'h20000;
    sGb[2] = 32'h300;  sSz[2] = 32'h100; sHb[2] = 32'h40000;
    loadSegs(1'b1);  // R5 junk host base in unused slot
    doReq("R2 seg0 start", 32'h0);
    doReq("R2 seg0 end", 32'hff);
    doReq("R3 seg1 start", 32'h100);
    doReq("R3 seg1 end", 32'h2ff);
    doReq("R4 last seg end", 32'h3ff);
    doReq("R4 past last", 32'h400);
    doReq("R5 past count with junk host", 32'h500);
    // R10 guest base 0 write ignored, out-of-range kind semantics kept
    wrCfg(1, 0, 32'h50);
    doReq("R10 guest0 write ignored", 32'h10);
    // R5 unused host base changed: no effect
    wrCfg(0, 3, 32'h7777_0000);
    doReq("R5 unused host ignored", 32'h3ff);

    // R8 R9 backpressure with a config write during hold
    @(negedge clk);
    rspReady = 1'b0; reqValid = 1'b1; reqGpa = 32'h100;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R8 valid next cycle", 64'(rspValid), 64'd1);
    check("R8 reqReady low", 64'(reqReady), 64'd0);
    cfgWrEn = 1'b1; cfgKind = 2'd2; cfgIdx = '0; cfgData = 32'd0;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    cfgWrEn = 1'b1; cfgKind = 2'd3; cfgData = 32'd0;
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    check("R8 held valid", 64'(rspValid), 64'd1);
    check("R8 held hpa", 64'(rspHpa), 64'h20000);
    rspReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 released", 64'(rspValid), 64'd0);
    doReq("R9 limit write ignored", 32'h3ff);
    doReq("R9 mode write ignored", 32'h150);

    // R7 bypass
    wrCfg(3, 0, 32'd0); modeOn = 1'b0;
    doReq("R7 bypass", 32'h1234_5678);
    wrCfg(3, 0, 32'h80); modeOn = 1'b1;
    doReq("R7 nonzero enables", 32'h150);

    // random layouts
    for (int t = 0; t < 24; t++) begin
      logic [AW-1:0] cur;
      kUsed = 1 + int'($urandom % N);
      cur = ($urandom % 4096) << 16;
      for (int j = 0; j < kUsed; j++) begin
        sSz[j] = (($urandom % 64) + 1) << 8;
        sGb[j] = (j == 0) ? 32'd0 : sGb[j-1] + sSz[j-1];
        cur = cur + (($urandom % 16) << 12);
        sHb[j] = cur;
        cur = cur + sSz[j];
      end
      loadSegs(1'b1);
      for (int r = 0; r < 30; r++) begin
        int s;
        logic [AW-1:0] g;
        s = int'($urandom % kUsed);
        case ($urandom % 5)
          0: g = sGb[s];
          1: g = sGb[s] + sSz[s] - 1;
          2: g = sGb[s] + sSz[s];
          3: g = $urandom;
          default: g = sGb[s] + ($urandom % sSz[s]);
        endcase
        doReq((s == 0) ? "R2 random" : ((s == kUsed - 1) ? "R4 random" : "R3 random"), g);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end
endmodule